// File: doc/BRIEF.md
# Operand-Snooping Reservation Station Array

This block buffers a handful of waiting instructions for one class of functional unit. An issue port writes an opcode and two source operands into a free entry. Each operand is given either as a value that is already known, or as the tag of the instruction that will produce it. A known value is copied into the entry, so later register writes never disturb it. A tagged operand waits for its result.

Every waiting operand slot compares its stored tag against a single result broadcast bus. The bus carries a valid bit, a tag and a value. On a match the slot takes the value, and the slot is ready from the next cycle. An entry whose two operands both hold values can be dispatched. When the functional unit is ready, the lowest-numbered such entry is handed over and its slot is freed. A per-entry squash mask discards speculative entries.

Top module: `rs_array`

## Requirements
- R1: After reset every entry is empty. `iss_full` is 0, and `disp_valid` is 0 even with `fu_ready` high.
- R2: Tag code 0 means "value supplied". An operand issued with tag 0 stores the issue value. No later broadcast changes that stored value.
- R3: An operand issued with a non-zero tag waits. It captures `bc_val` on a clock edge where `bc_valid` is 1 and `bc_tag` equals its tag. A broadcast whose valid bit is low, or whose tag differs, leaves the operand waiting.
- R4: A single broadcast wakes every matching slot in the same cycle. This covers both operands of one entry and operands in different entries.
- R5: An entry is offered for dispatch only when both of its operands hold values. An entry with one operand still waiting is never dispatched.
- R6: `disp_valid` is high only while `fu_ready` is high and at least one entry is eligible. At most one entry is dispatched per cycle, and it is always the lowest-index eligible entry.
- R7: A dispatched entry is freed at that clock edge. `iss_full` is 1 exactly when all entries are occupied, and an issue request made while it is 1 is dropped. A freed entry can be allocated in the next cycle.
- R8: If an operand is issued with tag T in the same cycle that a valid broadcast carries tag T, the broadcast value is stored and the operand is ready at once.
- R9: An entry whose `squash_mask` bit is 1 is removed at that clock edge. It is never dispatched, not even in the cycle of the squash.
- R10: Issue writes the lowest-index free entry. `disp_idx` reports the index of the entry being dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode of the issued instruction |
| iss_a_tag | input | TAG_W | Producer tag of operand A (0 = value given) |
| iss_a_val | input | DATA_W | Value of operand A when its tag is 0 |
| iss_b_tag | input | TAG_W | Producer tag of operand B (0 = value given) |
| iss_b_val | input | DATA_W | Value of operand B when its tag is 0 |
| iss_full | output | 1 | No free entry; issue is refused |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| squash_mask | input | ENTRIES | Per-entry squash request |
| fu_ready | input | 1 | Functional unit can accept an instruction |
| disp_valid | output | 1 | An instruction is dispatched this cycle |
| disp_idx | output | IDX_W | Entry index being dispatched |
| disp_op | output | OP_W | Dispatched opcode |
| disp_a | output | DATA_W | Dispatched operand A value |
| disp_b | output | DATA_W | Dispatched operand B value |

## Verification
Some internal faults show up at the ports within one or two cycles:

- A slot that misses a tag match stays waiting. Its entry then never reaches `disp_valid` in the cycle after the broadcast.
- A slot that latches on a wrong tag or a low valid bit dispatches early, or with a wrong operand value.
- A corrupted valid bit shows up in `iss_full`, or as a squashed or dropped instruction reappearing at dispatch.
- A wrong priority order shows up in `disp_idx` on the first cycle that two entries are eligible together.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int DATA_W = 16;
    localparam int TAG_W  = 3;
    localparam int OP_W   = 4;
    localparam logic [TAG_W-1:0] TAG_NONE = '0;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } oper_t;

    typedef struct packed {
        logic            valid;
        logic [OP_W-1:0] op;
        oper_t           a;
        oper_t           b;
    } slot_t;

    // Capture a broadcast into a waiting operand slot
    function automatic oper_t oper_snoop(input oper_t o, input logic bcv,
                                         input logic [TAG_W-1:0] bct,
                                         input logic [DATA_W-1:0] bcval);
        oper_t r;
        r = o;
        if (!o.rdy && bcv && (bct == o.tag)) begin
            r.rdy = 1'b1;
            r.val = bcval;
        end
        return r;
    endfunction

    // Build an operand slot at issue, including same-cycle broadcast capture
    function automatic oper_t oper_load(input logic [TAG_W-1:0] tag,
                                        input logic [DATA_W-1:0] val,
                                        input logic bcv,
                                        input logic [TAG_W-1:0] bct,
                                        input logic [DATA_W-1:0] bcval);
        oper_t r;
        if (tag == TAG_NONE) begin
            r.rdy = 1'b1;
            r.tag = TAG_NONE;
            r.val = val;
        end else begin
            r.rdy = 1'b0;
            r.tag = tag;
            r.val = '0;
            r = oper_snoop(r, bcv, bct, bcval);
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt = '0;
                gnt[i] = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    input  logic              kill,
    input  logic              grant,
    output slot_t             slot_q,
    output logic              eligible
);
    slot_t slot_d;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.valid) begin
            slot_d.a = oper_snoop(slot_q.a, bc_valid, bc_tag, bc_val);
            slot_d.b = oper_snoop(slot_q.b, bc_valid, bc_tag, bc_val);
        end
        if (kill || grant) slot_d.valid = 1'b0;
        if (alloc) begin
            slot_d.valid = 1'b1;
            slot_d.op    = iss_op;
            slot_d.a     = oper_load(iss_a_tag, iss_a_val, bc_valid, bc_tag, bc_val);
            slot_d.b     = oper_load(iss_b_tag, iss_b_val, bc_valid, bc_tag, bc_val);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign eligible = slot_q.valid && slot_q.a.rdy && slot_q.b.rdy;

    // R5
    grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (slot_q.valid && slot_q.a.rdy && slot_q.b.rdy));

    // R3
    wake_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.valid && !slot_q.a.rdy && bc_valid && bc_tag == slot_q.a.tag && !kill && !grant)
        |=> (slot_q.a.rdy && slot_q.a.val == $past(bc_val)));

    // R2
    copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.valid && slot_q.b.rdy && !kill && !grant && !alloc) |=> $stable(slot_q.b.val));

    // R9
    squash_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !alloc) |=> !slot_q.valid);
endmodule

// File: rtl/rs_array.sv
module rs_array
    import rs_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               iss_valid,
    input  logic [OP_W-1:0]    iss_op,
    input  logic [TAG_W-1:0]   iss_a_tag,
    input  logic [DATA_W-1:0]  iss_a_val,
    input  logic [TAG_W-1:0]   iss_b_tag,
    input  logic [DATA_W-1:0]  iss_b_val,
    output logic               iss_full,
    input  logic               bc_valid,
    input  logic [TAG_W-1:0]   bc_tag,
    input  logic [DATA_W-1:0]  bc_val,
    input  logic [ENTRIES-1:0] squash_mask,
    input  logic               fu_ready,
    output logic               disp_valid,
    output logic [IDX_W-1:0]   disp_idx,
    output logic [OP_W-1:0]    disp_op,
    output logic [DATA_W-1:0]  disp_a,
    output logic [DATA_W-1:0]  disp_b
);
    slot_t              slots [ENTRIES];
    logic [ENTRIES-1:0] free_vec, elig_raw, elig_vec;
    logic [ENTRIES-1:0] alloc_oh, alloc_vec, pick_oh, grant_vec;
    logic [IDX_W-1:0]   alloc_idx, pick_idx;
    logic               any_free, any_elig;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        rs_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc_vec[g]),
            .iss_op    (iss_op),
            .iss_a_tag (iss_a_tag),
            .iss_a_val (iss_a_val),
            .iss_b_tag (iss_b_tag),
            .iss_b_val (iss_b_val),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_val    (bc_val),
            .kill      (squash_mask[g]),
            .grant     (grant_vec[g]),
            .slot_q    (slots[g]),
            .eligible  (elig_raw[g])
        );
        assign free_vec[g] = !slots[g].valid;
    end

    assign elig_vec = elig_raw & ~squash_mask;

    rs_pick #(.N(ENTRIES), .IW(IDX_W)) u_alloc_pick (
        .req (free_vec), .gnt (alloc_oh), .idx (alloc_idx), .any (any_free)
    );

    rs_pick #(.N(ENTRIES), .IW(IDX_W)) u_disp_pick (
        .req (elig_vec), .gnt (pick_oh), .idx (pick_idx), .any (any_elig)
    );

    assign iss_full   = !any_free;
    assign alloc_vec  = iss_valid ? alloc_oh : '0;
    assign grant_vec  = fu_ready ? pick_oh : '0;
    assign disp_valid = fu_ready && any_elig;
    assign disp_idx   = pick_idx;

    always_comb begin
        disp_op = '0;
        disp_a  = '0;
        disp_b  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (pick_oh[i]) begin
                disp_op = slots[i].op;
                disp_a  = slots[i].a.val;
                disp_b  = slots[i].b.val;
            end
        end
    end

    // R6
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R7
    fill_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && $countones(free_vec) == 1 && grant_vec == '0 && squash_mask == '0)
        |=> iss_full);

    // R10
    alloc_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_full) |=> !free_vec[$past(alloc_idx)]);

    // R9
    no_squashed_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> !squash_mask[disp_idx]);
endmodule

// File: tb/rs_array_bench.sv
module rs_array_bench;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        iss_valid;
    logic [3:0]  iss_op;
    logic [2:0]  iss_a_tag, iss_b_tag, bc_tag;
    logic [15:0] iss_a_val, iss_b_val, bc_val;
    logic        iss_full, bc_valid, fu_ready, disp_valid;
    logic [N-1:0] squash_mask;
    logic [1:0]  disp_idx;
    logic [3:0]  disp_op;
    logic [15:0] disp_a, disp_b;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rs_array #(.ENTRIES(N)) u_rs_array (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val), .iss_full(iss_full),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .squash_mask(squash_mask), .fu_ready(fu_ready),
        .disp_valid(disp_valid), .disp_idx(disp_idx), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b)
    );

    typedef struct packed {
        logic [2:0]  a_tag; logic [15:0] a_val;
        logic [2:0]  b_tag; logic [15:0] b_val;
        logic        bc_v;  logic [2:0]  bc_t; logic [15:0] bc_d;
        logic        exp_v; logic [15:0] exp_a; logic [15:0] exp_b;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{3'd0, 16'h0005, 3'd0, 16'h0007, 1'b1, 3'd3, 16'h0099, 1'b1, 16'h0005, 16'h0007}, // R2
        '{3'd2, 16'h0000, 3'd0, 16'h0008, 1'b1, 3'd2, 16'h0011, 1'b1, 16'h0011, 16'h0008}, // R3
        '{3'd2, 16'h0000, 3'd2, 16'h0000, 1'b1, 3'd2, 16'h0022, 1'b1, 16'h0022, 16'h0022}, // R4
        '{3'd3, 16'h0000, 3'd0, 16'h0009, 1'b1, 3'd4, 16'h0033, 1'b0, 16'h0000, 16'h0000}, // R3
        '{3'd5, 16'h0000, 3'd0, 16'h0001, 1'b0, 3'd5, 16'h0044, 1'b0, 16'h0000, 16'h0000}, // R3
        '{3'd5, 16'h0000, 3'd6, 16'h0000, 1'b1, 3'd5, 16'h0055, 1'b0, 16'h0000, 16'h0000}, // R5
        '{3'd0, 16'h0066, 3'd7, 16'h0000, 1'b1, 3'd7, 16'h0067, 1'b1, 16'h0066, 16'h0067}  // R5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        iss_valid = 0; iss_op = 0; iss_a_tag = 0; iss_a_val = 0;
        iss_b_tag = 0; iss_b_val = 0; bc_valid = 0; bc_tag = 0; bc_val = 0;
        squash_mask = '0; fu_ready = 0;
    endtask

    task automatic issue(input logic [2:0] at, input logic [15:0] av,
                         input logic [2:0] bt, input logic [15:0] bv);
        @(negedge clk);
        idle();
        iss_valid = 1; iss_op = 4'h3; iss_a_tag = at; iss_a_val = av;
        iss_b_tag = bt; iss_b_val = bv;
    endtask

    task automatic flush();
        @(negedge clk);
        idle();
        squash_mask = '1;
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        fu_ready = 1; #2;
        chk("R1 full", iss_full, 0);
        chk("R1 disp", disp_valid, 0);

        // Vector table: issue, one broadcast cycle, then dispatch check
        for (int k = 0; k < 7; k++) begin
            issue(VECS[k].a_tag, VECS[k].a_val, VECS[k].b_tag, VECS[k].b_val);
            @(negedge clk);
            idle();
            bc_valid = VECS[k].bc_v; bc_tag = VECS[k].bc_t; bc_val = VECS[k].bc_d;
            @(negedge clk);
            idle();
            fu_ready = 1; #2;
            chk("R2/R3/R4/R5 table disp_valid", disp_valid, VECS[k].exp_v);
            if (VECS[k].exp_v) begin
                chk("R2/R3/R4 table a", disp_a, VECS[k].exp_a);
                chk("R2/R3/R4 table b", disp_b, VECS[k].exp_b);
                chk("R10 table idx", disp_idx, 0);
            end
            flush();
        end

        // R7 / R10 fill, refuse, reuse, ordering
        for (int i = 0; i < N; i++) issue(0, 16'(16'h10 + i), 0, 16'(i));
        @(negedge clk);
        idle(); #2;
        chk("R7 full when occupied", iss_full, 1);
        chk("R6 no disp without fu_ready", disp_valid, 0);
        iss_valid = 1; iss_a_val = 16'hEE;   // refused
        @(negedge clk);
        idle();
        fu_ready = 1; #2;
        chk("R6 lowest idx", disp_idx, 0);
        chk("R6 lowest a", disp_a, 16'h10);
        @(negedge clk);
        idle(); #2;
        chk("R7 freed after dispatch", iss_full, 0);
        iss_valid = 1; iss_a_val = 16'h55;   // reuse entry 0
        @(negedge clk);
        idle();
        fu_ready = 1; #2;
        chk("R7 reuse disp a", disp_a, 16'h55);
        chk("R10 reuse idx", disp_idx, 0);
        for (int i = 1; i < N; i++) begin
            @(negedge clk);
            #2;
            chk("R6 order idx", disp_idx, i);
            chk("R6 order a", disp_a, 16'(16'h10 + i));
        end
        @(negedge clk);
        #2;
        chk("R7 refused issue never stored", disp_valid, 0);

        // R8 same-cycle issue and broadcast
        issue(3'd4, 0, 0, 16'h3);
        bc_valid = 1; bc_tag = 3'd4; bc_val = 16'h77;
        @(negedge clk);
        idle();
        fu_ready = 1; #2;
        chk("R8 ready", disp_valid, 1);
        chk("R8 captured", disp_a, 16'h77);
        flush();

        // R4 one broadcast wakes two entries
        issue(3'd1, 0, 0, 16'h1);
        issue(0, 16'h2, 3'd1, 0);
        @(negedge clk);
        idle();
        bc_valid = 1; bc_tag = 3'd1; bc_val = 16'h40;
        @(negedge clk);
        idle();
        fu_ready = 1; #2;
        chk("R4 e0 a", disp_a, 16'h40);
        @(negedge clk);
        #2;
        chk("R4 e1 idx", disp_idx, 1);
        chk("R4 e1 b", disp_b, 16'h40);
        flush();

        // R9 squash excludes entry in the same cycle
        issue(0, 16'h1, 0, 0);
        issue(0, 16'h2, 0, 0);
        @(negedge clk);
        idle();
        fu_ready = 1; squash_mask = 4'b0001; #2;
        chk("R9 skip squashed idx", disp_idx, 1);
        chk("R9 skip squashed a", disp_a, 16'h2);
        @(negedge clk);
        idle();
        fu_ready = 1; #2;
        chk("R9 squashed gone", disp_valid, 0);
        issue(3'd2, 0, 0, 0);
        @(negedge clk);
        idle();
        squash_mask = 4'b0001;
        @(negedge clk);
        idle();
        bc_valid = 1; bc_tag = 3'd2; bc_val = 16'h9;
        @(negedge clk);
        idle();
        fu_ready = 1; #2;
        chk("R9 squashed waiter not woken", disp_valid, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule